// File: doc/BRIEF.md
# Three-Level Receive Alarm Interrupt Tree

This block collects receive-side alarm interrupts from up to 28 tributary channels and one path into a single registered interrupt line. Each source unit (every tributary, and the path) watches a vector of raw condition levels and a vector of single-cycle event pulses. It keeps three sticky groups of leaf status bits: onset (the condition rose), termination (the condition fell) and event (a pulse was seen). Each group has its own enable mask.

Above the leaves, each tributary produces a summary bit: the OR of its enabled leaf bits. The tributary summaries pass through a per-tributary enable and are ORed into a tributary-level bit. The path produces its own summary. These two top-level bits pass through a two-bit top enable and drive `irq`. Only leaf bits clear when read. The summary levels cannot be written or cleared; they fall on their own once the leaf bits beneath them are gone. A host reaches every status and enable register through a simple register bus with a single-cycle read strobe and a single-cycle write strobe.

Top module: `trib_irq_agg`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), every leaf status bit, every enable bit and `irq` are 0.
- R2: The onset bit of a condition sets at the clock edge where that condition input is first sampled 1 after having been sampled 0. It then stays set until it is cleared by a read.
- R3: The termination bit of a condition sets at the clock edge where that condition input is first sampled 0 after having been sampled 1.
- R4: The event bit of a condition sets at any clock edge where its event input is sampled 1.
- R5: Unit u (tributaries 0..NCH-1, path = NCH) uses addresses u*8 + k: k=0 onset status, 1 termination status, 2 event status, 3/4/5 the matching enables, with condition i at data bit i. A read returns the status in the same cycle as `rd` and clears that register at the clock edge. A write to a status register has no effect.
- R6: If a condition edge or event sets a leaf bit at the same edge where a read clears that register, the bit remains set.
- R7: The tributary summary bits are read-only at 0x100 + j (tributary t at byte t/8, bit t%8). Tributary summary t is the OR over its three groups of status AND enable. Reading a summary does not change it, and it drops once the leaf bits are cleared.
- R8: The read-only register 0x110 holds bit 0 = path summary and bit 1 = OR of (tributary summaries AND tributary enables). The tributary enables are read/write at 0x108 + j, with the same bit layout as R7. The top enable is read/write at 0x111, bits [1:0].
- R9: `irq` equals the OR of (0x110 bits AND top enable) one clock later. It is 0 in the cycle after the top enable reads 0, and it is only high when some leaf bit was set in the previous cycle.
- R10: Clearing an enable bit stops its leaf bit from reaching the summaries and `irq`, and leaves the leaf bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cond_trib | input | NCH*NCOND | Raw condition levels, tributary t at bits [t*NCOND +: NCOND] |
| evt_trib | input | NCH*NCOND | Single-cycle event pulses, same layout |
| cond_path | input | NCOND | Raw path condition levels |
| evt_path | input | NCOND | Path event pulses |
| addr | input | AW | Register address |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rd | input | 1 | Read strobe; clears the addressed leaf status register |
| rdata | output | 8 | Read data, combinational from `addr` |
| irq | output | 1 | Registered level-sensitive block interrupt |

## Verification
The hardest situation to reach is a new edge landing at exactly the clock edge where a read clears the same register. The bench drives the condition change and the read strobe on the same falling clock half. It confirms that the value read back was still zero and that a second read then shows the bit. A second hard case is the summary tree draining only after every leaf bit is gone. A long run toggles random conditions across all 28 tributaries and keeps a bench-side model of every onset and termination bit. It reads back every register against that model, and then checks that `irq` falls only after the last clearing read.

// File: rtl/trib_irq_agg.sv
`timescale 1ns/1ps
module trib_irq_agg #(
  parameter int NCH   = 28,
  parameter int NCOND = 8,
  parameter int AW    = 9
)(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NCH*NCOND-1:0]   cond_trib,
  input  logic [NCH*NCOND-1:0]   evt_trib,
  input  logic [NCOND-1:0]       cond_path,
  input  logic [NCOND-1:0]       evt_path,
  input  logic [AW-1:0]          addr,
  input  logic                   wr,
  input  logic [7:0]             wdata,
  input  logic                   rd,
  output logic [7:0]             rdata,
  output logic                   irq
);
  localparam int NU = NCH + 1;
  localparam int NB = (NCH + 7) / 8;
  localparam int IW = AW - 4;

  wire [NU*NCOND-1:0] cond_all = {cond_path, cond_trib};
  wire [NU*NCOND-1:0] evt_all  = {evt_path, evt_trib};
  wire                sel_top  = addr[AW-1];
  wire [IW-1:0]       uidx     = addr[AW-2:3];
  wire [2:0]          off      = addr[2:0];

  logic [NU*NCOND-1:0] st_s_f, st_e_f, st_v_f, ie_s_f, ie_e_f, ie_v_f;
  logic [NU-1:0]       unit_sum;
  logic [NB*8-1:0]     trib_en;
  logic [NB*8-1:0]     l2_pad;
  logic [1:0]          top_en;
  logic [1:0]          l3;

  for (genvar u = 0; u < NU; u++) begin : g_unit
    wire [NCOND-1:0] c   = cond_all[u*NCOND +: NCOND];
    wire [NCOND-1:0] e   = evt_all[u*NCOND +: NCOND];
    wire             hit = !sel_top && (uidx == IW'(u));
    wire             wipe_s = rd && hit && off == 3'd0;
    wire             wipe_e = rd && hit && off == 3'd1;
    wire             wipe_v = rd && hit && off == 3'd2;
    logic [NCOND-1:0] prev, ss, se, sv, es, ee, ev;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prev <= c;
        ss <= '0; se <= '0; sv <= '0;
        es <= '0; ee <= '0; ev <= '0;
      end else begin
        prev <= c;
        ss <= (wipe_s ? '0 : ss) | (c & ~prev);
        se <= (wipe_e ? '0 : se) | (~c & prev);
        sv <= (wipe_v ? '0 : sv) | e;
        if (wr && hit && off == 3'd3) es <= wdata[NCOND-1:0];
        if (wr && hit && off == 3'd4) ee <= wdata[NCOND-1:0];
        if (wr && hit && off == 3'd5) ev <= wdata[NCOND-1:0];
      end
    end

    assign st_s_f[u*NCOND +: NCOND] = ss;
    assign st_e_f[u*NCOND +: NCOND] = se;
    assign st_v_f[u*NCOND +: NCOND] = sv;
    assign ie_s_f[u*NCOND +: NCOND] = es;
    assign ie_e_f[u*NCOND +: NCOND] = ee;
    assign ie_v_f[u*NCOND +: NCOND] = ev;
    assign unit_sum[u] = |{ss & es, se & ee, sv & ev};
  end

  assign l2_pad = (NB*8)'(unit_sum[NCH-1:0]);
  assign l3     = {|(l2_pad & trib_en), unit_sum[NCH]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trib_en <= '0;
      top_en  <= '0;
      irq     <= 1'b0;
    end else begin
      if (wr && sel_top) begin
        if (addr[4:3] == 2'd1 && 32'(addr[2:0]) < NB) trib_en[addr[2:0]*8 +: 8] <= wdata;
        if (addr[4:0] == 5'd17) top_en <= wdata[1:0];
      end
      irq <= |(l3 & top_en);
    end
  end

  always_comb begin
    rdata = '0;
    if (sel_top) begin
      if (addr[4:3] == 2'd0 && 32'(addr[2:0]) < NB)      rdata = l2_pad[addr[2:0]*8 +: 8];
      else if (addr[4:3] == 2'd1 && 32'(addr[2:0]) < NB) rdata = trib_en[addr[2:0]*8 +: 8];
      else if (addr[4:0] == 5'd16)                       rdata = {6'd0, l3};
      else if (addr[4:0] == 5'd17)                       rdata = {6'd0, top_en};
    end else if (32'(uidx) < NU) begin
      case (off)
        3'd0: rdata[NCOND-1:0] = st_s_f[uidx*NCOND +: NCOND];
        3'd1: rdata[NCOND-1:0] = st_e_f[uidx*NCOND +: NCOND];
        3'd2: rdata[NCOND-1:0] = st_v_f[uidx*NCOND +: NCOND];
        3'd3: rdata[NCOND-1:0] = ie_s_f[uidx*NCOND +: NCOND];
        3'd4: rdata[NCOND-1:0] = ie_e_f[uidx*NCOND +: NCOND];
        3'd5: rdata[NCOND-1:0] = ie_v_f[uidx*NCOND +: NCOND];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/trib_irq_agg_chk.sv
`timescale 1ns/1ps
module trib_irq_agg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cond0,
  input logic       evt0,
  input logic       rd_s0,
  input logic       s0,
  input logic       e0,
  input logic       v0,
  input logic       any_st,
  input logic [1:0] top_en,
  input logic       irq
);
  p_onset_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cond0) |=> s0);

  p_term_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cond0) |=> e0);

  p_event_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    evt0 |=> v0);

  p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_s0 && !$rose(cond0)) |=> !s0);

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (s0 && !rd_s0) |=> s0);

  p_masked_top_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (top_en == 2'b00) |=> !irq);

  p_irq_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(any_st));
endmodule

bind trib_irq_agg trib_irq_agg_chk chk_i (
  .clk    (clk),
  .rst_n  (rst_n),
  .cond0  (cond_trib[0]),
  .evt0   (evt_trib[0]),
  .rd_s0  (rd && addr == '0),
  .s0     (st_s_f[0]),
  .e0     (st_e_f[0]),
  .v0     (st_v_f[0]),
  .any_st (|{st_s_f, st_e_f, st_v_f}),
  .top_en (top_en),
  .irq    (irq)
);

// File: tb/trib_irq_agg_tb_top.sv
`timescale 1ns/1ps
module trib_irq_agg_tb_top;
  localparam int NCH = 28;
  localparam int NCOND = 8;
  localparam int AW = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH*NCOND-1:0] cond_trib = '0;
  logic [NCH*NCOND-1:0] evt_trib = '0;
  logic [NCOND-1:0] cond_path = '0;
  logic [NCOND-1:0] evt_path = '0;
  logic [AW-1:0] addr = '0;
  logic wr = 1'b0;
  logic [7:0] wdata = '0;
  logic rd = 1'b0;
  logic [7:0] rdata;
  logic irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  trib_irq_agg #(.NCH(NCH), .NCOND(NCOND), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cond_trib(cond_trib), .evt_trib(evt_trib),
    .cond_path(cond_path), .evt_path(evt_path), .addr(addr), .wr(wr),
    .wdata(wdata), .rd(rd), .rdata(rdata), .irq(irq));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_reg(input int a, output logic [7:0] d);
    @(negedge clk);
    addr = AW'(a); rd = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic wr_reg(input int a, input logic [7:0] d);
    @(negedge clk);
    addr = AW'(a); wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic expect_reg(input int a, input logic [7:0] exp, input string req);
    logic [7:0] d;
    rd_reg(a, d);
    chk(d == exp, req, d, exp);
  endtask

  task automatic t_reset;
    chk(irq == 1'b0, "R1 irq", irq, 0);
    expect_reg(0, 8'h00, "R1 onset status");
    expect_reg(5*8+3, 8'h00, "R1 onset enable");
    expect_reg(9'h108, 8'h00, "R1 tributary enable");
    expect_reg(9'h111, 8'h00, "R1 top enable");
  endtask

  task automatic t_edges;
    wr_reg(5*8+3, 8'hFF); wr_reg(5*8+4, 8'hFF); wr_reg(5*8+5, 8'hFF);
    wr_reg(9'h108, 8'h20); wr_reg(9'h111, 8'h03);
    @(negedge clk) cond_trib[5*NCOND+2] = 1'b1;
    cyc(3);
    chk(irq == 1'b1, "R9 irq from onset", irq, 1);
    expect_reg(5*8+0, 8'h04, "R2 onset on rise");
    expect_reg(5*8+0, 8'h00, "R5 cleared by read");
    cyc(2);
    chk(irq == 1'b0, "R9 irq drops after clear", irq, 0);
    @(negedge clk) cond_trib[5*NCOND+2] = 1'b0;
    cyc(1);
    expect_reg(5*8+1, 8'h04, "R3 termination on fall");
    @(negedge clk) evt_trib[5*NCOND+7] = 1'b1;
    @(negedge clk) evt_trib[5*NCOND+7] = 1'b0;
    expect_reg(5*8+2, 8'h80, "R4 event pulse");
    expect_reg(5*8+2, 8'h00, "R4 event cleared");
  endtask

  task automatic t_write_ignored;
    @(negedge clk) cond_trib[5*NCOND+1] = 1'b1;
    cyc(1);
    wr_reg(5*8+0, 8'h00);
    expect_reg(5*8+0, 8'h02, "R5 status write ignored");
    @(negedge clk) cond_trib[5*NCOND+1] = 1'b0;
    cyc(1);
    expect_reg(5*8+1, 8'h02, "R3 termination again");
  endtask

  task automatic t_collide;
    logic [7:0] d;
    @(negedge clk);
    addr = AW'(3*8); rd = 1'b1; cond_trib[3*NCOND+0] = 1'b1;
    #1 d = rdata;
    @(negedge clk) rd = 1'b0;
    chk(d == 8'h00, "R6 read before set", d, 0);
    expect_reg(3*8, 8'h01, "R6 set survives clearing read");
    @(negedge clk) cond_trib[3*NCOND+0] = 1'b0;
    cyc(1);
    expect_reg(3*8+1, 8'h01, "R3 collide cleanup");
  endtask

  task automatic t_tree;
    @(negedge clk) cond_trib[9*NCOND+6] = 1'b1;
    cyc(2);
    expect_reg(9'h101, 8'h00, "R10 disabled leaf hidden from summary");
    wr_reg(9*8+3, 8'h40);
    expect_reg(9'h101, 8'h02, "R7 summary set");
    expect_reg(9'h101, 8'h02, "R7 summary not cleared by read");
    expect_reg(9'h110, 8'h00, "R8 tributary enable blocks");
    wr_reg(9'h109, 8'h02);
    expect_reg(9'h110, 8'h02, "R8 tributary summary bit");
    cyc(2);
    chk(irq == 1'b1, "R9 irq via tributary", irq, 1);
    wr_reg(9*8+3, 8'h00);
    cyc(2);
    chk(irq == 1'b0, "R10 irq masked", irq, 0);
    expect_reg(9*8, 8'h40, "R10 leaf unchanged by mask");
    wr_reg(9*8+3, 8'h40);
    expect_reg(9'h101, 8'h00, "R7 summary drops after leaf clear");
    wr_reg(9'h111, 8'h00);
    @(negedge clk) cond_trib[9*NCOND+6] = 1'b0;
    @(negedge clk) cond_trib[9*NCOND+6] = 1'b1;
    cyc(3);
    chk(irq == 1'b0, "R9 top enable zero", irq, 0);
    expect_reg(9*8+1, 8'h40, "R3 tree termination");
    expect_reg(9*8, 8'h40, "R2 tree onset");
    @(negedge clk) cond_trib[9*NCOND+6] = 1'b0;
    cyc(1);
    expect_reg(9*8+1, 8'h40, "R3 tree final");
  endtask

  task automatic t_path;
    wr_reg(NCH*8+3, 8'h01);
    wr_reg(9'h111, 8'h01);
    @(negedge clk) cond_path[0] = 1'b1;
    cyc(3);
    chk(irq == 1'b1, "R9 irq via path", irq, 1);
    expect_reg(9'h110, 8'h01, "R8 path summary bit");
    expect_reg(NCH*8, 8'h01, "R2 path onset");
    cyc(2);
    chk(irq == 1'b0, "R9 path drained", irq, 0);
  endtask

  task automatic t_random;
    logic [7:0] ms [NCH];
    logic [7:0] me [NCH];
    logic [7:0] d;
    for (int t = 0; t < NCH; t++) begin
      wr_reg(t*8+3, 8'hFF); wr_reg(t*8+4, 8'hFF);
      rd_reg(t*8, d); rd_reg(t*8+1, d); rd_reg(t*8+2, d);
      ms[t] = '0; me[t] = '0;
    end
    for (int j = 0; j < NB_T; j++) wr_reg(9'h108 + j, 8'hFF);
    wr_reg(9'h111, 8'h02);
    for (int k = 0; k < 300; k++) begin
      int ch = int'($urandom_range(NCH-1, 0));
      int b  = int'($urandom_range(NCOND-1, 0));
      @(negedge clk);
      cond_trib[ch*NCOND+b] = ~cond_trib[ch*NCOND+b];
      if (cond_trib[ch*NCOND+b]) ms[ch][b] = 1'b1;
      else me[ch][b] = 1'b1;
    end
    cyc(3);
    chk(irq == 1'b1, "R9 irq after random toggles", irq, 1);
    for (int t = 0; t < NCH; t++) begin
      expect_reg(t*8, ms[t], "R2 random onset");
      expect_reg(t*8+1, me[t], "R3 random termination");
    end
    cyc(2);
    chk(irq == 1'b0, "R9 irq after all reads", irq, 0);
    expect_reg(9'h110, 8'h00, "R8 tree drained");
  endtask

  localparam int NB_T = (NCH + 7) / 8;

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset;
    t_edges;
    t_write_ignored;
    t_collide;
    t_tree;
    t_path;
    t_random;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule